// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block takes up to eight asynchronous interrupt pins from outside the chip and turns them into interrupt requests for a processor. Each pin passes through a synchronizer. A detector then looks for the trigger condition chosen for that pin, which can be an edge, both edges or a level. When the condition is seen, the pin's pending flag is latched.

Each pin has two gates between its pending flag and its interrupt output:
- a mask bit, set and cleared through two separate write-only addresses;
- a 4-bit gate field, where the value zero blocks the pin.

The block drives one request line per pin and one combined line. Software talks to the block over a simple single-cycle register bus. The bus can make word (32-bit) or byte (8-bit) accesses.

Register indices on `bus_addr`:

| Index | Register |
|-------|----------|
| 0 | trigger mode |
| 1 | gate |
| 2 | pending |
| 3 | mask-set |
| 4 | mask-clear |

In every per-pin register, pin 0 sits at the most significant end.

Top module: `extirq_ctrl`

## Requirements
- R1: After reset, every pin is masked and every gate field is 0. All pending flags are clear and every trigger field is 0. `irq_out` and `irq_any` are low, and reads of indices 0, 1 and 2 return 0.
- R2: Bit placement in the pending, mask-set and mask-clear registers:
  - A word access (`bus_word`=1) places pin n at bit 31-n.
  - A byte access (`bus_word`=0) places pin n at bit 7-n of `bus_wdata` or `bus_rdata`, and `bus_rdata[31:8]` reads 0.
- R3: The trigger register gives each pin a 4-bit field at bits [31-4n : 28-4n], so pin 0 uses bits 31:28. The register reads back what was written.
- R4: Edge trigger codes are 0 for a falling edge, 1 for a rising edge and 4 for either edge. An edge on the pin sets its pending flag, and the flag is readable within four clock cycles. An edge in the other direction does not set it (codes 0 and 1).
- R5: Level trigger codes are 2 for low and 3 for high. The pending flag is set on every cycle the level is active, so a clear has no lasting effect until the level goes inactive.
- R6: Trigger codes 5 to 15 never set the pending flag.
- R7: A write to the pending register clears each flag whose bit is 0 and leaves each flag whose bit is 1. A read returns the flags.
- R8: A 1 written to a pin's bit at mask-set masks the pin, and a 1 at mask-clear unmasks it. Zero bits have no effect. Both indices read as 0.
- R9: A gate field of 0 holds the pin's request low, while the pending flag still latches and can be read. Any nonzero gate field lets the request through.
- R10: `irq_out[n]` is high exactly when pin n is pending, unmasked and has a nonzero gate field. `irq_any` is the OR of all `irq_out` bits.
- R11: If a pin detects an event in the same cycle that software clears its pending flag, the flag stays set.
- R12: The trigger and gate registers are always written as full 32-bit words, whatever `bus_word` says.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | NUM_PINS | Asynchronous external interrupt pins |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_word | input | 1 | 1 for a 32-bit access, 0 for an 8-bit access |
| bus_addr | input | 3 | Register index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the addressed register |
| irq_out | output | NUM_PINS | Per-pin interrupt requests |
| irq_any | output | 1 | OR of all per-pin requests |

## Verification
The bench builds the block with its defaults: `NUM_PINS`=8 and `SYNC_STAGES`=2.

With a full set of eight pins, the bench can reach:
- pin 7 at bit 24 of a word access and bit 0 of a byte access;
- every trigger field from bits 31:28 down to 3:0.

With the two-stage synchronizer, the latency from a pin change to its pending flag is a fixed three edges. That fixed latency lets the bench line up a pin event with a pending-flag clear in the very same cycle.

// File: rtl/extirq_pkg.sv
// Shared constants and types for the external interrupt pin controller.
// Assumes a 32-bit register bus and 4-bit per-pin fields in the trigger
// and gate registers.
package extirq_pkg;

    localparam int REG_W    = 32;
    localparam int FIELD_W  = 4;
    localparam int MAX_PINS = 8;
    localparam int BYTE_W   = 8;

    // Register indices on bus_addr; order is the software-visible map.
    localparam logic [2:0] IDX_MODE = 3'd0;
    localparam logic [2:0] IDX_GATE = 3'd1;
    localparam logic [2:0] IDX_PEND = 3'd2;
    localparam logic [2:0] IDX_MSET = 3'd3;
    localparam logic [2:0] IDX_MCLR = 3'd4;

    // Trigger codes held in each 4-bit trigger field.
    typedef enum logic [3:0] {
        TRIG_FALL = 4'd0,
        TRIG_RISE = 4'd1,
        TRIG_LOW  = 4'd2,
        TRIG_HIGH = 4'd3,
        TRIG_BOTH = 4'd4
    } trig_e;

    // Lowest bit of pin n's field; pin 0 owns the top field.
    function automatic int field_lsb(input int pin);
        return REG_W - (pin + 1) * FIELD_W;
    endfunction

endpackage

// File: rtl/extirq_sync.sv
// Multi-flop synchronizer for one asynchronous pin.
// Assumes STAGES >= 2; the output resets to 0.
module extirq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain_q;

    // Shift the raw pin through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/extirq_detect.sv
// Trigger detector for one synchronized pin.
// Edge codes compare the current level with the level one cycle earlier.
// Level codes report an event on every active cycle.
// Codes outside the defined set report nothing.
module extirq_detect
    import extirq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] code,
    input  logic       lvl,
    output logic       evt
);

    logic prev_q;

    // Remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    // Decode the trigger code into an event strobe.
    always_comb begin
        case (code)
            TRIG_FALL: evt = prev_q & ~lvl;
            TRIG_RISE: evt = ~prev_q & lvl;
            TRIG_LOW:  evt = ~lvl;
            TRIG_HIGH: evt = lvl;
            TRIG_BOTH: evt = prev_q ^ lvl;
            default:   evt = 1'b0;
        endcase
    end

endmodule

// File: rtl/extirq_regs.sv
// Register file: trigger and gate words, pending flags, mask flags and
// the read multiplexer.
// Per-pin bits are MSB-first at both access sizes.
// Trigger and gate registers always take the full word.
// A new event overrides a software clear in the same cycle.
module extirq_regs
    import extirq_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bus_sel,
    input  logic                              bus_wr,
    input  logic                              bus_word,
    input  logic [2:0]                        bus_addr,
    input  logic [REG_W-1:0]                  bus_wdata,
    output logic [REG_W-1:0]                  bus_rdata,
    input  logic [NUM_PINS-1:0]               evt_i,
    output logic [NUM_PINS-1:0][FIELD_W-1:0]  mode_o,
    output logic [NUM_PINS-1:0]               gate_on_o,
    output logic [NUM_PINS-1:0]               pend_o,
    output logic [NUM_PINS-1:0]               mask_o
);

    logic [REG_W-1:0]    mode_q;
    logic [REG_W-1:0]    gate_q;
    logic [NUM_PINS-1:0] pend_q;
    logic [NUM_PINS-1:0] mask_q;
    logic [NUM_PINS-1:0] wbit;
    logic                wr_mode, wr_gate, wr_pend, wr_mset, wr_mclr;

    // Decode which register a write targets.
    always_comb begin
        wr_mode = bus_sel && bus_wr && (bus_addr == IDX_MODE);
        wr_gate = bus_sel && bus_wr && (bus_addr == IDX_GATE);
        wr_pend = bus_sel && bus_wr && (bus_addr == IDX_PEND);
        wr_mset = bus_sel && bus_wr && (bus_addr == IDX_MSET);
        wr_mclr = bus_sel && bus_wr && (bus_addr == IDX_MCLR);
    end

    // Extract per-pin write bits, MSB-first within the access width.
    always_comb begin
        for (int n = 0; n < NUM_PINS; n++) begin
            wbit[n] = bus_word ? bus_wdata[REG_W-1-n] : bus_wdata[BYTE_W-1-n];
        end
    end

    // Trigger and gate words: full-word writes only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            gate_q <= '0;
        end else begin
            if (wr_mode) mode_q <= bus_wdata;
            if (wr_gate) gate_q <= bus_wdata;
        end
    end

    genvar g;
    generate
        for (g = 0; g < NUM_PINS; g++) begin : g_pin
            localparam int LSB = field_lsb(g);

            // Pending flag: write-0-to-clear, an event sets it with priority.
            always_ff @(posedge clk) begin
                if (!rst_n)       pend_q[g] <= 1'b0;
                else if (evt_i[g]) pend_q[g] <= 1'b1;
                else if (wr_pend)  pend_q[g] <= pend_q[g] & wbit[g];
            end

            // Mask flag: set through one index, cleared through another.
            always_ff @(posedge clk) begin
                if (!rst_n)                  mask_q[g] <= 1'b1;
                else if (wr_mset && wbit[g]) mask_q[g] <= 1'b1;
                else if (wr_mclr && wbit[g]) mask_q[g] <= 1'b0;
            end

            assign mode_o[g]    = mode_q[LSB +: FIELD_W];
            assign gate_on_o[g] = |gate_q[LSB +: FIELD_W];
        end
    endgenerate

    // Read multiplexer; the mask indices are write-only and read as zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            IDX_MODE: bus_rdata = mode_q;
            IDX_GATE: bus_rdata = gate_q;
            IDX_PEND: begin
                for (int n = 0; n < NUM_PINS; n++) begin
                    if (bus_word) bus_rdata[REG_W-1-n]  = pend_q[n];
                    else          bus_rdata[BYTE_W-1-n] = pend_q[n];
                end
            end
            default:  bus_rdata = '0;
        endcase
    end

    assign pend_o = pend_q;
    assign mask_o = mask_q;

endmodule

// File: rtl/extirq_ctrl.sv
// Top level of the external interrupt pin controller.
// Each pin runs through a synchronizer and a trigger detector into the
// register file.
// Requests are formed from the pending flag, the mask flag and the gate field.
// Assumes 1 <= NUM_PINS <= 8 and SYNC_STAGES >= 2.
module extirq_ctrl
    import extirq_pkg::*;
#(
    parameter int NUM_PINS    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic                bus_word,
    input  logic [2:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic [NUM_PINS-1:0] irq_out,
    output logic                irq_any
);

    logic [NUM_PINS-1:0]              pin_s;
    logic [NUM_PINS-1:0]              evt;
    logic [NUM_PINS-1:0][FIELD_W-1:0] mode;
    logic [NUM_PINS-1:0]              gate_on;
    logic [NUM_PINS-1:0]              pend;
    logic [NUM_PINS-1:0]              mask;

    genvar g;
    generate
        for (g = 0; g < NUM_PINS; g++) begin : g_pin
            extirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk   (clk),
                .rst_n (rst_n),
                .d     (pin_in[g]),
                .q     (pin_s[g])
            );

            extirq_detect u_det (
                .clk   (clk),
                .rst_n (rst_n),
                .code  (mode[g]),
                .lvl   (pin_s[g]),
                .evt   (evt[g])
            );

            // Request: pending, unmasked and gated on.
            assign irq_out[g] = pend[g] & ~mask[g] & gate_on[g];
        end
    endgenerate

    extirq_regs #(.NUM_PINS(NUM_PINS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_word  (bus_word),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .evt_i     (evt),
        .mode_o    (mode),
        .gate_on_o (gate_on),
        .pend_o    (pend),
        .mask_o    (mask)
    );

    assign irq_any = |irq_out;

endmodule

// File: rtl/extirq_checker.sv
// Port-level assertions for extirq_ctrl, attached by bind.
// Assumes the register indices from extirq_pkg.
module extirq_checker
    import extirq_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_sel,
    input logic                bus_wr,
    input logic                bus_word,
    input logic [2:0]          bus_addr,
    input logic [31:0]         bus_wdata,
    input logic [31:0]         bus_rdata,
    input logic [NUM_PINS-1:0] irq_out,
    input logic                irq_any
);

    // R1: the first cycle out of reset shows no request.
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq_out == '0) && !irq_any);

    // R8: reads of the write-only mask indices return zero.
    a_r8_mask_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && (bus_addr == IDX_MSET || bus_addr == IDX_MCLR))
        |-> (bus_rdata == '0));

    genvar g;
    generate
        for (g = 0; g < NUM_PINS; g++) begin : g_pin
            localparam int LSB = field_lsb(g);

            // R8: setting a pin's mask silences its request the next cycle.
            a_r8_mask_silences: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_sel && bus_wr && bus_addr == IDX_MSET &&
                 (bus_word ? bus_wdata[31-g] : bus_wdata[7-g]))
                |=> !irq_out[g]);

            // R9: a zero gate field silences the pin's request the next cycle.
            a_r9_gate_zero: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_sel && bus_wr && bus_addr == IDX_GATE &&
                 bus_wdata[LSB +: FIELD_W] == '0)
                |=> !irq_out[g]);
        end
    endgenerate

endmodule

bind extirq_ctrl extirq_checker #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_word  (bus_word),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .irq_any   (irq_any)
);

// File: tb/sim_extirq_ctrl.sv
module sim_extirq_ctrl;

    localparam int NP = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pin_in = '0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_word = 1'b1;
    logic [2:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] irq_out;
    logic          irq_any;

    int total = 0;
    int bad   = 0;
    logic [31:0] rd;

    always #5 clk = ~clk;

    extirq_ctrl #(.NUM_PINS(NP), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_word(bus_word),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out), .irq_any(irq_any)
    );

    // Vector fields: {pin[9:7], code[6:3], before[2], after[1], expect[0]}.
    localparam logic [9:0] VEC [0:11] = '{
        {3'd0, 4'd1,  1'b0, 1'b1, 1'b1},  // R4 rising seen
        {3'd0, 4'd1,  1'b1, 1'b0, 1'b0},  // R4 falling ignored in rise mode
        {3'd1, 4'd0,  1'b1, 1'b0, 1'b1},  // R4 falling seen
        {3'd1, 4'd0,  1'b0, 1'b1, 1'b0},  // R4 rising ignored in fall mode
        {3'd2, 4'd4,  1'b0, 1'b1, 1'b1},  // R4 both, up
        {3'd2, 4'd4,  1'b1, 1'b0, 1'b1},  // R4 both, down
        {3'd3, 4'd3,  1'b0, 1'b1, 1'b1},  // R5 level high active
        {3'd3, 4'd2,  1'b1, 1'b0, 1'b1},  // R5 level low active
        {3'd4, 4'd3,  1'b0, 1'b0, 1'b0},  // R5 level high inactive
        {3'd5, 4'd7,  1'b0, 1'b1, 1'b0},  // R6 code 7 disabled
        {3'd6, 4'd15, 1'b1, 1'b0, 1'b0},  // R6 code 15 disabled
        {3'd7, 4'd1,  1'b0, 1'b1, 1'b1}   // R3 last field, rising
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [2:0] a, input logic word, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_word = word; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, input logic word, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_word = word; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic do_reset();
        pin_in = '0;
        @(negedge clk); rst_n = 1'b0;
        cycles(3);
        rst_n = 1'b1;
        cycles(1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        do_reset();

        // R1: reset state.
        check("R1 irq_out", 32'(irq_out), 32'h0);
        check("R1 irq_any", 32'(irq_any), 32'h0);
        bus_read(3'd0, 1'b1, rd); check("R1 mode", rd, 32'h0);
        bus_read(3'd1, 1'b1, rd); check("R1 gate", rd, 32'h0);
        bus_read(3'd2, 1'b1, rd); check("R1 pend", rd, 32'h0);

        // Open all gates and unmask all pins for the vector walk.
        bus_write(3'd1, 1'b1, 32'hFFFF_FFFF);
        bus_write(3'd4, 1'b0, 32'h0000_00FF);

        // R3 R4 R5 R6: trigger vectors.
        for (int i = 0; i < 12; i++) begin
            int          p;
            logic [3:0]  c;
            logic [31:0] mw;
            p  = int'(VEC[i][9:7]);
            c  = VEC[i][6:3];
            pin_in[p] = VEC[i][2];
            cycles(4);
            mw = 32'(c) << (28 - 4 * p);
            bus_write(3'd0, 1'b1, mw);
            bus_read(3'd0, 1'b1, rd); check("R3 mode readback", rd, mw);
            bus_write(3'd2, 1'b1, 32'h0);
            pin_in[p] = VEC[i][1];
            cycles(4);
            bus_read(3'd2, 1'b1, rd);
            check("R4/R5/R6 pending bit", 32'(rd[31-p]), 32'(VEC[i][0]));
            check("R10 irq_out bit", 32'(irq_out[p]), 32'(VEC[i][0]));
        end

        // R9 gate blocks while pending still latches.
        do_reset();
        bus_write(3'd0, 1'b1, 32'h1000_0000);
        bus_write(3'd4, 1'b0, 32'h0000_0080);
        pin_in[0] = 1'b1;
        cycles(4);
        check("R9 gated irq low", 32'(irq_out[0]), 32'h0);
        bus_read(3'd2, 1'b1, rd); check("R9 pending latched", rd, 32'h8000_0000);
        bus_write(3'd1, 1'b1, 32'hF000_0000);
        check("R10 irq on", 32'(irq_out), 32'h1);
        check("R10 irq_any on", 32'(irq_any), 32'h1);

        // R8 mask set, zero-bit no effect, unmask.
        bus_write(3'd3, 1'b0, 32'h0000_0080);
        check("R8 masked", 32'(irq_out[0]), 32'h0);
        bus_read(3'd3, 1'b1, rd); check("R8 mask-set reads 0", rd, 32'h0);
        bus_read(3'd4, 1'b1, rd); check("R8 mask-clear reads 0", rd, 32'h0);
        bus_write(3'd4, 1'b1, 32'h0);
        check("R8 zero clear no effect", 32'(irq_out[0]), 32'h0);
        bus_write(3'd4, 1'b1, 32'h8000_0000);
        check("R8 unmasked", 32'(irq_out[0]), 32'h1);

        // R2 bit placement for byte and word reads.
        bus_read(3'd2, 1'b0, rd); check("R2 byte read", rd, 32'h0000_0080);
        bus_read(3'd2, 1'b1, rd); check("R2 word read", rd, 32'h8000_0000);

        // R7 write-0-to-clear with ones preserved.
        bus_write(3'd2, 1'b1, 32'hFFFF_FFFF);
        bus_read(3'd2, 1'b1, rd); check("R7 ones keep", rd, 32'h8000_0000);
        bus_write(3'd0, 1'b1, 32'h1100_0000);
        bus_write(3'd1, 1'b1, 32'hFF00_0000);
        bus_write(3'd4, 1'b0, 32'h0000_00C0);
        pin_in[1] = 1'b1;
        cycles(4);
        bus_read(3'd2, 1'b1, rd); check("R7 two pending", rd, 32'hC000_0000);
        bus_write(3'd2, 1'b0, 32'h0000_00BF);
        bus_read(3'd2, 1'b1, rd); check("R7 selective clear", rd, 32'h8000_0000);
        check("R10 irq_any one pin", 32'(irq_any), 32'h1);
        bus_write(3'd2, 1'b1, 32'h0);
        check("R10 irq_any none", 32'(irq_any), 32'h0);
        check("R7 all clear outputs", 32'(irq_out), 32'h0);

        // R11 event and clear in the same cycle.
        pin_in[0] = 1'b0;
        cycles(4);
        bus_write(3'd2, 1'b1, 32'h0);
        @(negedge clk); pin_in[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_word = 1'b1; bus_addr = 3'd2; bus_wdata = 32'h0;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        bus_read(3'd2, 1'b1, rd); check("R11 event wins", rd, 32'h8000_0000);

        // R5 level: clear does not stick while active.
        bus_write(3'd0, 1'b1, 32'h0000_3000);
        bus_write(3'd2, 1'b1, 32'h0);
        pin_in[4] = 1'b1;
        cycles(4);
        bus_write(3'd2, 1'b1, 32'h0);
        bus_read(3'd2, 1'b1, rd); check("R5 level re-sets", 32'(rd[27]), 32'h1);
        pin_in[4] = 1'b0;
        cycles(4);
        bus_write(3'd2, 1'b1, 32'h0);
        bus_read(3'd2, 1'b1, rd); check("R5 clear after inactive", 32'(rd[27]), 32'h0);

        // R12 byte access to trigger/gate still writes full word.
        bus_write(3'd0, 1'b0, 32'h2000_0000);
        bus_read(3'd0, 1'b1, rd); check("R12 mode full word", rd, 32'h2000_0000);
        bus_write(3'd1, 1'b0, 32'h0A00_0000);
        bus_read(3'd1, 1'b0, rd); check("R12 gate full word", rd, 32'h0A00_0000);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule